// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block models the read side of a parallel NOR flash device while its internal controller runs a program or a block erase. It keeps track of whether the controller is idle, programming, erasing, or holding an erase in suspension. For every bus read strobe it decides whether to return the contents of a small internal array or a status byte. Bit 7 of the status byte is a polling flag that depends on the data or operation. Bit 6 flips on each read while the operation runs.

System-level models drive it with start pulses carrying a target, suspend and resume requests, and a done strobe that stands in for the end of the cell timing. Software-style polling loops read the data bus to see when an operation has finished or has been suspended. The array is 2^ADDR_W bytes and is split into 2^BLK_W equal blocks. The block number is the top BLK_W address bits.

Top module: `flsr_status_responder`

## Requirements
- R1: After reset the controller is idle, `rd_data` is 0x00, and every array byte holds 0xFF.
- R2: While idle, a read strobe at address A loads the array byte at A into `rd_data` at the next clock edge. Without a strobe, `rd_data` keeps its value.
- R3: While a program or erase is active, every read returns a status byte whatever the address. Bits 5..0 of that byte are 0.
- R4: During a program, status bit 7 is the inverse of bit 7 of the byte being programmed.
- R5: During an erase, status bit 7 is 0.
- R6: Status bit 6 is 0 on the first read after any start. It inverts after each read taken while a program or erase is active.
- R7: A done strobe during a program writes the data to its address and returns to idle. A later read there returns the true byte.
- R8: A done strobe during an erase writes 0xFF to every byte of the erased block and returns to idle. Other blocks are untouched.
- R9: A suspend request during an erase enters the suspended state. There, reads inside the erased block return bit 7 = 1 with bit 6 frozen, and reads outside it return array data.
- R10: A resume request returns to erasing, with bit 7 = 0 and bit 6 toggling again from its frozen value. A done strobe while suspended has no effect.
- R11: Start pulses are ignored unless the controller is idle. If program and erase start in the same idle cycle, the program wins.
- R12: A read in the same cycle as a start, done or suspend returns the response for the state before that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_start | input | 1 | Begin program of `prog_data` at `prog_addr` |
| prog_addr | input | ADDR_W | Program target address |
| prog_data | input | DATA_W | Byte to program |
| erase_start | input | 1 | Begin erase of block `erase_blk` |
| erase_blk | input | BLK_W | Block to erase |
| suspend_req | input | 1 | Suspend a running erase |
| resume_req | input | 1 | Resume a suspended erase |
| op_done | input | 1 | Operation-complete strobe |
| rd_strobe | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Bus read address |
| rd_data | output | DATA_W | Registered read data |

## Verification
The key overlap is a bus read landing in the same cycle as a state change: completion of an erase, a program start from idle, or a suspend. The bench raises `rd_strobe` together with `op_done` or `prog_start` in a single cycle. It expects the pre-event answer: a status byte with the current toggle value for the completing erase, and plain array data for the starting program. The next read must then show the post-event view, either the erased 0xFF or a program status byte.

// File: rtl/flsr_pkg.sv
package flsr_pkg;

    typedef enum logic [1:0] {
        ST_READ  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2,
        ST_SUSP  = 2'd3
    } flsr_state_e;

    localparam int POLL_BIT   = 7;
    localparam int TOGGLE_BIT = 6;

endpackage

// File: rtl/flsr_ctrl.sv
module flsr_ctrl
    import flsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BLK_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_start,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_start,
    input  logic [BLK_W-1:0]  erase_blk,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic              op_done,
    input  logic              rd_strobe,
    output flsr_state_e       state_o,
    output logic              tog_o,
    output logic [ADDR_W-1:0] tgt_addr_o,
    output logic [DATA_W-1:0] tgt_data_o,
    output logic [BLK_W-1:0]  tgt_blk_o,
    output logic              prog_commit_o,
    output logic              erase_commit_o
);

    typedef struct packed {
        flsr_state_e       state;
        logic              tog;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BLK_W-1:0]  blk;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  prog_commit_d, erase_commit_d;

    always_comb begin
        ctl_d          = ctl_q;
        prog_commit_d  = 1'b0;
        erase_commit_d = 1'b0;
        case (ctl_q.state)
            ST_READ: begin
                if (prog_start) begin
                    ctl_d.state = ST_PROG;
                    ctl_d.addr  = prog_addr;
                    ctl_d.data  = prog_data;
                    ctl_d.tog   = 1'b0;
                end else if (erase_start) begin
                    ctl_d.state = ST_ERASE;
                    ctl_d.blk   = erase_blk;
                    ctl_d.tog   = 1'b0;
                end
            end
            ST_PROG: begin
                if (rd_strobe) ctl_d.tog = ~ctl_q.tog;
                if (op_done) begin
                    ctl_d.state   = ST_READ;
                    prog_commit_d = 1'b1;
                end
            end
            ST_ERASE: begin
                if (rd_strobe) ctl_d.tog = ~ctl_q.tog;
                if (op_done) begin
                    ctl_d.state    = ST_READ;
                    erase_commit_d = 1'b1;
                end else if (suspend_req) begin
                    ctl_d.state = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (resume_req) ctl_d.state = ST_ERASE;
            end
            default: ctl_d.state = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_READ, tog: 1'b0, addr: '0, data: '0, blk: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state_o        = ctl_q.state;
    assign tog_o          = ctl_q.tog;
    assign tgt_addr_o     = ctl_q.addr;
    assign tgt_data_o     = ctl_q.data;
    assign tgt_blk_o      = ctl_q.blk;
    assign prog_commit_o  = prog_commit_d;
    assign erase_commit_o = erase_commit_d;

    // R11: a running program keeps its target until done
    a_r11_prog_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_PROG && !op_done) |=>
        (ctl_q.state == ST_PROG && $stable(ctl_q.addr) && $stable(ctl_q.data)));

    // R9: toggle is frozen while suspended
    a_r9_tog_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_SUSP) |=> $stable(ctl_q.tog));

    // R10: done strobe has no effect while suspended
    a_r10_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_SUSP && op_done && !resume_req) |=> (ctl_q.state == ST_SUSP));

    // R6: toggle cleared on start
    a_r6_tog_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_READ && (prog_start || erase_start)) |=> !ctl_q.tog);

    // R6: toggle flips on each active read
    a_r6_tog_flips: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_q.state == ST_PROG || ctl_q.state == ST_ERASE) && rd_strobe) |=>
        (ctl_q.tog != $past(ctl_q.tog)));

endmodule

// File: rtl/flsr_array.sv
module flsr_array #(
    parameter int ADDR_W = 6,
    parameter int BLK_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_commit,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_commit,
    input  logic [BLK_W-1:0]  erase_blk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int OFF_W = ADDR_W - BLK_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (erase_commit && erase_blk == BLK_W'(i >> OFF_W)) begin
                mem_d[i] = '1;
            end else if (prog_commit && prog_addr == ADDR_W'(i)) begin
                mem_d[i] = prog_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_word = mem_q[rd_addr];

    // R7: committed program byte lands at its address
    a_r7_prog_written: assert property (@(posedge clk) disable iff (!rst_n)
        prog_commit |=> (mem_q[$past(prog_addr)] == $past(prog_data)));

    // R8: first and last byte of an erased block read all ones
    a_r8_block_filled: assert property (@(posedge clk) disable iff (!rst_n)
        erase_commit |=> (mem_q[{$past(erase_blk), {OFF_W{1'b0}}}] == '1 &&
                          mem_q[{$past(erase_blk), {OFF_W{1'b1}}}] == '1));

endmodule

// File: rtl/flsr_rdpath.sv
module flsr_rdpath
    import flsr_pkg::*;
#(
    parameter int BLK_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  flsr_state_e       state,
    input  logic              tog,
    input  logic              tgt_msb,
    input  logic [BLK_W-1:0]  tgt_blk,
    input  logic              rd_strobe,
    input  logic [BLK_W-1:0]  rd_blk,
    input  logic [DATA_W-1:0] arr_word,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] rd_d, rd_q, status;
    logic              busy, in_susp_blk, use_status, poll;

    always_comb begin
        busy        = (state == ST_PROG) || (state == ST_ERASE);
        in_susp_blk = (state == ST_SUSP) && (rd_blk == tgt_blk);
        use_status  = busy || in_susp_blk;
        case (state)
            ST_PROG:  poll = ~tgt_msb;
            ST_ERASE: poll = 1'b0;
            default:  poll = 1'b1;
        endcase
        status             = '0;
        status[POLL_BIT]   = poll;
        status[TOGGLE_BIT] = tog;
        rd_d = rd_q;
        if (rd_strobe) rd_d = use_status ? status : arr_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    // R2: output holds without a strobe
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> $stable(rd_q));

    // R3: low status bits are zero during an active operation
    a_r3_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && (state == ST_PROG || state == ST_ERASE)) |=> (rd_q[5:0] == 6'd0));

    // R4: program polling bit inverts the target msb
    a_r4_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && state == ST_PROG) |=> (rd_q[7] == !$past(tgt_msb)));

    // R5: erase polling bit reads zero
    a_r5_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && state == ST_ERASE) |=> !rd_q[7]);

    // R9: suspended-block read shows polling bit set
    a_r9_susp_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && state == ST_SUSP && rd_blk == tgt_blk) |=> rd_q[7]);

endmodule

// File: rtl/flsr_status_responder.sv
module flsr_status_responder
    import flsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BLK_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_start,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_start,
    input  logic [BLK_W-1:0]  erase_blk,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic              op_done,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    flsr_state_e       state;
    logic              tog, prog_commit, erase_commit;
    logic [ADDR_W-1:0] tgt_addr;
    logic [DATA_W-1:0] tgt_data, arr_word;
    logic [BLK_W-1:0]  tgt_blk;

    flsr_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .prog_start     (prog_start),
        .prog_addr      (prog_addr),
        .prog_data      (prog_data),
        .erase_start    (erase_start),
        .erase_blk      (erase_blk),
        .suspend_req    (suspend_req),
        .resume_req     (resume_req),
        .op_done        (op_done),
        .rd_strobe      (rd_strobe),
        .state_o        (state),
        .tog_o          (tog),
        .tgt_addr_o     (tgt_addr),
        .tgt_data_o     (tgt_data),
        .tgt_blk_o      (tgt_blk),
        .prog_commit_o  (prog_commit),
        .erase_commit_o (erase_commit)
    );

    flsr_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_array (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_commit  (prog_commit),
        .prog_addr    (tgt_addr),
        .prog_data    (tgt_data),
        .erase_commit (erase_commit),
        .erase_blk    (tgt_blk),
        .rd_addr      (rd_addr),
        .rd_word      (arr_word)
    );

    flsr_rdpath #(.BLK_W(BLK_W), .DATA_W(DATA_W)) u_rdpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .tog       (tog),
        .tgt_msb   (tgt_data[DATA_W-1]),
        .tgt_blk   (tgt_blk),
        .rd_strobe (rd_strobe),
        .rd_blk    (rd_addr[ADDR_W-1 -: BLK_W]),
        .arr_word  (arr_word),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/flsr_status_responder_test.sv
module flsr_status_responder_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_start = 0, erase_start = 0, suspend_req = 0, resume_req = 0;
    logic       op_done = 0, rd_strobe = 0;
    logic [5:0] prog_addr = 0, rd_addr = 0;
    logic [7:0] prog_data = 0;
    logic [1:0] erase_blk = 0;
    logic [7:0] rd_data;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    flsr_status_responder uut (
        .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_start(erase_start), .erase_blk(erase_blk),
        .suspend_req(suspend_req), .resume_req(resume_req), .op_done(op_done),
        .rd_strobe(rd_strobe), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // {address, data} pairs programmed by the vector loop
    localparam logic [13:0] VEC [4] = '{
        {6'h05, 8'hA5}, {6'h13, 8'h3C}, {6'h2F, 8'h80}, {6'h3A, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // one cycle of stimulus, then all strobes cleared
    task automatic cyc(input logic ps, input logic es, input logic su, input logic re,
                       input logic dn, input logic rs, input logic [5:0] ra,
                       input logic [5:0] pa, input logic [7:0] pd, input logic [1:0] eb);
        @(negedge clk);
        prog_start = ps; erase_start = es; suspend_req = su; resume_req = re;
        op_done = dn; rd_strobe = rs; rd_addr = ra; prog_addr = pa;
        prog_data = pd; erase_blk = eb;
        @(negedge clk);
        prog_start = 0; erase_start = 0; suspend_req = 0; resume_req = 0;
        op_done = 0; rd_strobe = 0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string req);
        cyc(0, 0, 0, 0, 0, 1, a, 0, 0, 0);
        chk(req, rd_data, exp);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset output", rd_data, 8'h00);
        rst_n = 1'b1;
        rd(6'h00, 8'hFF, "R1 erased after reset");
        rd(6'h3F, 8'hFF, "R2 idle read");
        repeat (3) @(negedge clk);
        chk("R2 hold without strobe", rd_data, 8'hFF);

        // vector loop: program, poll status three times, complete, read back
        foreach (VEC[i]) begin
            logic [5:0] a;
            logic [7:0] d;
            a = VEC[i][13:8];
            d = VEC[i][7:0];
            cyc(1, 0, 0, 0, 0, 0, 0, a, d, 0);
            rd(a ^ 6'h11, {~d[7], 7'h00}, "R3 R4 R6 first status");
            rd(a,         {~d[7], 7'h40}, "R4 R6 second status");
            rd(6'h00,     {~d[7], 7'h00}, "R6 third status");
            cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
            rd(a, d, "R7 true data after program");
        end

        // erase block 1 with suspend / resume
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 2'd1);
        rd(6'h13, 8'h00, "R5 erase status");
        rd(6'h30, 8'h40, "R3 R6 erase toggle");
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        rd(6'h13, 8'h80, "R9 suspended block status");
        rd(6'h1F, 8'h80, "R9 toggle frozen");
        rd(6'h05, 8'hA5, "R9 outside block array data");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        rd(6'h13, 8'h80, "R10 done ignored in suspend");
        cyc(1, 0, 0, 0, 0, 0, 0, 6'h05, 8'h00, 0);
        rd(6'h05, 8'hA5, "R11 start ignored in suspend");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        rd(6'h2F, 8'h00, "R10 resumed erase status");
        rd(6'h05, 8'h40, "R10 toggle resumes");
        // R12: read in the same cycle as completion
        cyc(0, 0, 0, 0, 1, 1, 6'h13, 0, 0, 0);
        chk("R12 read with done sees status", rd_data, 8'h00);
        rd(6'h13, 8'hFF, "R8 erased byte");
        rd(6'h1F, 8'hFF, "R8 erased last byte");
        rd(6'h2F, 8'h80, "R8 other block untouched");
        rd(6'h05, 8'hA5, "R8 block 0 untouched");

        // simultaneous starts: program wins
        cyc(1, 1, 0, 0, 0, 0, 0, 6'h20, 8'h11, 2'd3);
        rd(6'h3A, 8'h80, "R11 program wins");
        cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 2'd3);
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        rd(6'h3A, 8'h00, "R11 erase start ignored while busy");
        rd(6'h20, 8'h11, "R7 programmed byte");

        // R12: read in the same cycle as a program start
        cyc(1, 0, 0, 0, 0, 1, 6'h05, 6'h06, 8'h7F, 0);
        chk("R12 read with start sees array", rd_data, 8'hA5);
        rd(6'h06, 8'h80, "R4 msb zero gives poll one");
        cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        rd(6'h06, 8'h7F, "R7 read back");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule